// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for indirect loads and stores. Each generator owns four pointer sets; a set holds an index (the pointer), a modifier (signed step), a length and a base. A request names one set, an addressing mode and an optional signed 8-bit step. The block returns the effective address together with the value the selected index register holds after the access. Two generators sit side by side, so two pointer updates can happen in the same cycle.

Circular buffering keeps a pointer inside the window from base up to base plus length. The step is added to the index. If the sum has reached the top of the window, one length is taken off. If it has fallen below the base, one length is added. A zero length turns wrapping off, and the sum then rolls over modulo 2^16. Pre-modify mode puts the stepped value on the address and leaves the pointer alone. Post-modify mode puts the old pointer on the address and stores the stepped value. Pointer sets are loaded through a separate write port on each generator.

Top module: `cbuf_agu_top`

## Requirements
- R1: While `rst` is high and after it, `addr_valid`, `addr_out` and `idx_out` are zero, and every index, modifier, length and base register is zero.
- R2: `wr_kind` picks the register to load: 00 index, 01 modifier, 10 length, 11 base. A load takes effect at the clock edge, so a request in the same cycle still uses the old modifier, length and base.
- R3: Post-modify (`req_mode` bit 1 = 0): `addr_out` is the current index. The stepped and wrapped value is written back to the index, and `idx_out` shows it.
- R4: Pre-modify (`req_mode` bit 1 = 1): `addr_out` is the stepped and wrapped value. The index register is unchanged, and `idx_out` shows it.
- R5: `req_mode` bit 0 = 1 uses `req_imm` as a sign-extended two's-complement step. Bit 0 = 0 uses the 16-bit modifier register, and `req_imm` is then ignored.
- R6: With a nonzero length, a sum at or above base + length has one length subtracted.
- R7: With a nonzero length, a sum below the base has one length added.
- R8: With length zero, the result is index + step modulo 2^16.
- R9: `addr_valid` is high exactly in the cycle after a cycle with `req_valid`. In a cycle with no request, `addr_out` and `idx_out` keep their values.
- R10: If the same cycle has an index load and a request on the same set, the loaded value wins. `idx_out` then shows the loaded value, and `addr_out` still uses the old index.
- R11: The two generators have separate registers and ports. Requests on both in the same cycle are each served correctly.
- R12: `req_sel` and `wr_sel` pick one of four sets. Accesses and loads on one set do not change another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_GEN | Access request, one bit per generator |
| req_sel | input | NUM_GEN x 2 | Pointer set used by the request |
| req_mode | input | NUM_GEN x 2 | Bit 1: pre-modify; bit 0: immediate step |
| req_imm | input | NUM_GEN x 8 | Signed immediate step |
| wr_en | input | NUM_GEN | Register load strobe |
| wr_sel | input | NUM_GEN x 2 | Pointer set to load |
| wr_kind | input | NUM_GEN x 2 | Register to load (index, modifier, length, base) |
| wr_data | input | NUM_GEN x 16 | Load value |
| addr_valid | output | NUM_GEN | Effective address valid |
| addr_out | output | NUM_GEN x 16 | Effective address |
| idx_out | output | NUM_GEN x 16 | Index register value after the access |

## Verification
The address, the reported index and the valid flag all sit behind one register stage. They are due in the cycle after the request is sampled. The bench drives on the falling edge, lets one rising edge pass, and samples at the next falling edge. A post-modify write-back reaches the index register on that same edge. It is confirmed by a zero-step post-modify readback one cycle after that. The hold check on R9 samples one further idle cycle later.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        MODE_POST_REG = 2'b00,
        MODE_POST_IMM = 2'b01,
        MODE_PRE_REG  = 2'b10,
        MODE_PRE_IMM  = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        RK_INDEX  = 2'b00,
        RK_MODIFY = 2'b01,
        RK_LENGTH = 2'b10,
        RK_BASE   = 2'b11
    } reg_kind_e;

    function automatic logic mode_is_pre(addr_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_uses_imm(addr_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/dag_reg_bank.sv
module dag_reg_bank
    import dag_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSETS = 4,
    localparam int SELW = $clog2(NSETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SELW-1:0] rd_sel_i,
    output logic [AW-1:0]   idx_rd_o,
    output logic [AW-1:0]   mod_rd_o,
    output logic [AW-1:0]   len_rd_o,
    output logic [AW-1:0]   base_rd_o,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  reg_kind_e       wr_kind_i,
    input  logic [AW-1:0]   wr_data_i,
    input  logic            upd_en_i,
    input  logic [SELW-1:0] upd_sel_i,
    input  logic [AW-1:0]   upd_data_i
);

    logic [AW-1:0] idx_r  [NSETS];
    logic [AW-1:0] mod_r  [NSETS];
    logic [AW-1:0] len_r  [NSETS];
    logic [AW-1:0] base_r [NSETS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic wr_hit;
        logic upd_hit;
        assign wr_hit  = wr_en_i && (wr_sel_i == SELW'(s));
        assign upd_hit = upd_en_i && (upd_sel_i == SELW'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                idx_r[s]  <= '0;
                mod_r[s]  <= '0;
                len_r[s]  <= '0;
                base_r[s] <= '0;
            end else begin
                if (wr_hit && wr_kind_i == RK_INDEX) begin
                    idx_r[s] <= wr_data_i;
                end else if (upd_hit) begin
                    idx_r[s] <= upd_data_i;
                end
                if (wr_hit && wr_kind_i == RK_MODIFY) mod_r[s]  <= wr_data_i;
                if (wr_hit && wr_kind_i == RK_LENGTH) len_r[s]  <= wr_data_i;
                if (wr_hit && wr_kind_i == RK_BASE)   base_r[s] <= wr_data_i;
            end
        end
    end

    assign idx_rd_o  = idx_r[rd_sel_i];
    assign mod_rd_o  = mod_r[rd_sel_i];
    assign len_rd_o  = len_r[rd_sel_i];
    assign base_rd_o = base_r[rd_sel_i];

endmodule

// File: rtl/dag_circ_adder.sv
module dag_circ_adder #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] next_o
);

    localparam int EW = AW + 2;

    logic signed [EW-1:0] s_sum;
    logic signed [EW-1:0] s_lo;
    logic signed [EW-1:0] s_hi;
    logic signed [EW-1:0] s_len;
    logic signed [EW-1:0] s_adj;

    always_comb begin
        s_len = $signed({2'b00, len_i});
        s_lo  = $signed({2'b00, base_i});
        s_hi  = s_lo + s_len;
        s_sum = $signed({2'b00, idx_i}) + $signed({{2{step_i[AW-1]}}, step_i});
        if (len_i == '0) begin
            s_adj = s_sum;
        end else if (s_sum >= s_hi) begin
            s_adj = s_sum - s_len;
        end else if (s_sum < s_lo) begin
            s_adj = s_sum + s_len;
        end else begin
            s_adj = s_sum;
        end
    end

    assign next_o = s_adj[AW-1:0];

endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSETS = 4,
    parameter int IMMW  = 8,
    localparam int SELW = $clog2(NSETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid_i,
    input  logic [SELW-1:0] req_sel_i,
    input  addr_mode_e      req_mode_i,
    input  logic [IMMW-1:0] req_imm_i,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  reg_kind_e       wr_kind_i,
    input  logic [AW-1:0]   wr_data_i,
    output logic            addr_valid_o,
    output logic [AW-1:0]   addr_o,
    output logic [AW-1:0]   idx_o,
    output logic [AW-1:0]   idx_rd_o,
    output logic [AW-1:0]   len_rd_o
);

    logic [AW-1:0] idx_rd, mod_rd, len_rd, base_rd;
    logic [AW-1:0] step, next_val;
    logic          is_pre, conflict, upd_en;

    dag_reg_bank #(.AW(AW), .NSETS(NSETS)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .rd_sel_i   (req_sel_i),
        .idx_rd_o   (idx_rd),
        .mod_rd_o   (mod_rd),
        .len_rd_o   (len_rd),
        .base_rd_o  (base_rd),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_kind_i  (wr_kind_i),
        .wr_data_i  (wr_data_i),
        .upd_en_i   (upd_en),
        .upd_sel_i  (req_sel_i),
        .upd_data_i (next_val)
    );

    assign step = mode_uses_imm(req_mode_i)
                ? {{(AW-IMMW){req_imm_i[IMMW-1]}}, req_imm_i}
                : mod_rd;

    dag_circ_adder #(.AW(AW)) add_i (
        .idx_i  (idx_rd),
        .step_i (step),
        .base_i (base_rd),
        .len_i  (len_rd),
        .next_o (next_val)
    );

    assign is_pre   = mode_is_pre(req_mode_i);
    assign conflict = wr_en_i && (wr_kind_i == RK_INDEX) && (wr_sel_i == req_sel_i);
    assign upd_en   = req_valid_i && !is_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid_o <= 1'b0;
            addr_o       <= '0;
            idx_o        <= '0;
        end else begin
            addr_valid_o <= req_valid_i;
            if (req_valid_i) begin
                addr_o <= is_pre ? next_val : idx_rd;
                if (conflict)    idx_o <= wr_data_i;
                else if (is_pre) idx_o <= idx_rd;
                else             idx_o <= next_val;
            end
        end
    end

    assign idx_rd_o = idx_rd;
    assign len_rd_o = len_rd;

endmodule

// File: rtl/cbuf_agu_top.sv
module cbuf_agu_top
    import dag_pkg::*;
#(
    parameter int NUM_GEN = 2,
    parameter int AW      = 16,
    parameter int NSETS   = 4,
    parameter int IMMW    = 8,
    localparam int SELW   = $clog2(NSETS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_GEN-1:0]            req_valid,
    input  logic [NUM_GEN-1:0][SELW-1:0]  req_sel,
    input  logic [NUM_GEN-1:0][1:0]       req_mode,
    input  logic [NUM_GEN-1:0][IMMW-1:0]  req_imm,
    input  logic [NUM_GEN-1:0]            wr_en,
    input  logic [NUM_GEN-1:0][SELW-1:0]  wr_sel,
    input  logic [NUM_GEN-1:0][1:0]       wr_kind,
    input  logic [NUM_GEN-1:0][AW-1:0]    wr_data,
    output logic [NUM_GEN-1:0]            addr_valid,
    output logic [NUM_GEN-1:0][AW-1:0]    addr_out,
    output logic [NUM_GEN-1:0][AW-1:0]    idx_out
);

    logic [NUM_GEN-1:0][AW-1:0] idx_rd_all;
    logic [NUM_GEN-1:0][AW-1:0] len_rd_all;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        dag_unit #(.AW(AW), .NSETS(NSETS), .IMMW(IMMW)) unit_i (
            .clk          (clk),
            .rst          (rst),
            .req_valid_i  (req_valid[g]),
            .req_sel_i    (req_sel[g]),
            .req_mode_i   (addr_mode_e'(req_mode[g])),
            .req_imm_i    (req_imm[g]),
            .wr_en_i      (wr_en[g]),
            .wr_sel_i     (wr_sel[g]),
            .wr_kind_i    (reg_kind_e'(wr_kind[g])),
            .wr_data_i    (wr_data[g]),
            .addr_valid_o (addr_valid[g]),
            .addr_o       (addr_out[g]),
            .idx_o        (idx_out[g]),
            .idx_rd_o     (idx_rd_all[g]),
            .len_rd_o     (len_rd_all[g])
        );
    end

endmodule

// File: rtl/cbuf_agu_chk.sv
module cbuf_agu_chk #(
    parameter int NUM_GEN = 2,
    parameter int AW      = 16,
    parameter int NSETS   = 4,
    parameter int IMMW    = 8,
    localparam int SELW   = $clog2(NSETS)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_GEN-1:0]            req_valid,
    input logic [NUM_GEN-1:0][SELW-1:0]  req_sel,
    input logic [NUM_GEN-1:0][1:0]       req_mode,
    input logic [NUM_GEN-1:0][IMMW-1:0]  req_imm,
    input logic [NUM_GEN-1:0]            wr_en,
    input logic [NUM_GEN-1:0][SELW-1:0]  wr_sel,
    input logic [NUM_GEN-1:0][1:0]       wr_kind,
    input logic [NUM_GEN-1:0][AW-1:0]    wr_data,
    input logic [NUM_GEN-1:0]            addr_valid,
    input logic [NUM_GEN-1:0][AW-1:0]    addr_out,
    input logic [NUM_GEN-1:0][AW-1:0]    idx_out,
    input logic [NUM_GEN-1:0][AW-1:0]    idx_rd_all,
    input logic [NUM_GEN-1:0][AW-1:0]    len_rd_all
);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        logic hit;
        logic [AW-1:0] imm_ext;
        assign hit = wr_en[g] && (wr_kind[g] == 2'b00) && (wr_sel[g] == req_sel[g]);
        assign imm_ext = {{(AW-IMMW){req_imm[g][IMMW-1]}}, req_imm[g]};

        a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
            req_valid[g] |=> addr_valid[g]);

        a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
            !req_valid[g] |=> !addr_valid[g] && $stable(addr_out[g]) && $stable(idx_out[g]));

        a_r3_post_addr_is_index: assert property (@(posedge clk) disable iff (rst)
            req_valid[g] && !req_mode[g][1] |=> addr_out[g] == $past(idx_rd_all[g]));

        a_r4_pre_keeps_index: assert property (@(posedge clk) disable iff (rst)
            req_valid[g] && req_mode[g][1] && !hit |=> idx_out[g] == $past(idx_rd_all[g]));

        a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
            req_valid[g] && hit |=> idx_out[g] == $past(wr_data[g]));

        a_r8_flat_pre_imm: assert property (@(posedge clk) disable iff (rst)
            req_valid[g] && req_mode[g] == 2'b11 && len_rd_all[g] == '0
            |=> addr_out[g] == $past(idx_rd_all[g] + imm_ext));
    end

endmodule

bind cbuf_agu_top cbuf_agu_chk #(
    .NUM_GEN(NUM_GEN), .AW(AW), .NSETS(NSETS), .IMMW(IMMW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .req_mode   (req_mode),
    .req_imm    (req_imm),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_kind    (wr_kind),
    .wr_data    (wr_data),
    .addr_valid (addr_valid),
    .addr_out   (addr_out),
    .idx_out    (idx_out),
    .idx_rd_all (idx_rd_all),
    .len_rd_all (len_rd_all)
);

// File: tb/cbuf_agu_top_tb_top.sv
`timescale 1ns/1ps
module cbuf_agu_top_tb_top;
    import dag_pkg::*;

    localparam int NG = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NG-1:0]        req_valid = '0;
    logic [NG-1:0][1:0]   req_sel   = '0;
    logic [NG-1:0][1:0]   req_mode  = '0;
    logic [NG-1:0][7:0]   req_imm   = '0;
    logic [NG-1:0]        wr_en     = '0;
    logic [NG-1:0][1:0]   wr_sel    = '0;
    logic [NG-1:0][1:0]   wr_kind   = '0;
    logic [NG-1:0][15:0]  wr_data   = '0;
    logic [NG-1:0]        addr_valid;
    logic [NG-1:0][15:0]  addr_out;
    logic [NG-1:0][15:0]  idx_out;

    int vectors = 0;
    int errs    = 0;
    bit done    = 0;

    int mI [NG][4];
    int mM [NG][4];
    int mL [NG][4];
    int mB [NG][4];

    always #4 clk = ~clk;

    cbuf_agu_top dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_sel(req_sel), .req_mode(req_mode), .req_imm(req_imm),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_kind(wr_kind), .wr_data(wr_data),
        .addr_valid(addr_valid), .addr_out(addr_out), .idx_out(idx_out)
    );

    function automatic int wrapf(int i, int m, int b, int l);
        int s = i + m;
        if (l != 0) begin
            if (s >= b + l) s -= l;
            else if (s < b) s += l;
        end
        return s & 32'hFFFF;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        wr_en     = '0;
    endtask

    task automatic set_req(int g, logic [1:0] mode, int s, logic [7:0] imm);
        req_valid[g] = 1'b1;
        req_mode[g]  = mode;
        req_sel[g]   = 2'(s);
        req_imm[g]   = imm;
    endtask

    task automatic set_wr(int g, reg_kind_e k, int s, int d);
        wr_en[g]   = 1'b1;
        wr_kind[g] = k;
        wr_sel[g]  = 2'(s);
        wr_data[g] = 16'(d);
        case (k)
            RK_INDEX:  mI[g][s] = d & 32'hFFFF;
            RK_MODIFY: mM[g][s] = int'($signed(16'(d)));
            RK_LENGTH: mL[g][s] = d & 32'hFFFF;
            default:   mB[g][s] = d & 32'hFFFF;
        endcase
    endtask

    task automatic do_access(int g, logic [1:0] mode, int s, logic [7:0] imm, string tag);
        int mod, i, nxt, ea, ei;
        mod = mode[0] ? int'($signed(imm)) : mM[g][s];
        i   = mI[g][s];
        nxt = wrapf(i, mod, mB[g][s], mL[g][s]);
        ea  = mode[1] ? nxt : i;
        ei  = mode[1] ? i : nxt;
        set_req(g, mode, s, imm);
        step();
        chk({tag, " R9 valid"}, int'(addr_valid[g]), 1);
        chk({tag, " addr"}, int'(addr_out[g]), ea);
        chk({tag, " idx"}, int'(idx_out[g]), ei);
        if (!mode[1]) mI[g][s] = nxt;
        set_req(g, MODE_POST_IMM, s, 8'h00);
        step();
        chk({tag, mode[1] ? " R4 unchanged" : " R3 writeback"}, int'(addr_out[g]), mI[g][s]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < NG; g++)
            for (int s = 0; s < 4; s++) begin
                mI[g][s] = 0; mM[g][s] = 0; mL[g][s] = 0; mB[g][s] = 0;
            end
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(addr_valid), 0);
        chk("R1 addr in reset", int'(addr_out), 0);
        chk("R1 idx in reset", int'(idx_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", int'(addr_valid), 0);
        // R1: registers reset to zero; a pre-modify step of 3 from index 0 gives 3
        set_req(1, MODE_PRE_IMM, 2, 8'd3);
        step();
        chk("R1 reset index", int'(addr_out[1]), 3);
        chk("R1 reset index kept", int'(idx_out[1]), 0);

        // Sweep: R3 R4 R5 R6 R7 over every index in a 10-entry window
        for (int g = 0; g < NG; g++) begin
            int s = g + 1;
            int b = 100 + 50 * g;
            set_wr(g, RK_BASE, s, b);   step();
            set_wr(g, RK_LENGTH, s, 10); step();
            for (int i = 0; i < 10; i++)
                for (int m = -10; m <= 10; m++)
                    for (int md = 0; md < 4; md++) begin
                        string tag;
                        int sum = b + i + m;
                        tag = $sformatf("g%0d i%0d m%0d mode%0d %s %s", g, i, m, md,
                                        (sum >= b + 10) ? "R6" : (sum < b) ? "R7" : "in-window",
                                        md[0] ? "R5 imm" : "R5 reg");
                        set_wr(g, RK_INDEX, s, b + i); step();
                        if (!md[0]) begin
                            set_wr(g, RK_MODIFY, s, m); step();
                        end
                        do_access(g, 2'(md), s, md[0] ? 8'(m) : 8'h7F, tag);
                    end
        end

        // R8: zero length rolls over modulo 2^16
        set_wr(0, RK_INDEX, 3, 16'hFFFE); step();
        do_access(0, MODE_POST_IMM, 3, 8'd5, "R8 up rollover");
        chk("R8 up value", mI[0][3], 3);
        set_wr(1, RK_INDEX, 3, 2); step();
        do_access(1, MODE_PRE_IMM, 3, 8'hFB, "R8 down rollover");
        set_wr(1, RK_MODIFY, 3, 16'h8000); step();
        do_access(1, MODE_POST_REG, 3, 8'h00, "R8 reg rollover");

        // R10: same-cycle index load beats post-modify write-back
        set_wr(0, RK_INDEX, 0, 40); step();
        set_req(0, MODE_POST_IMM, 0, 8'd3);
        set_wr(0, RK_INDEX, 0, 77);
        step();
        chk("R10 addr old index", int'(addr_out[0]), 40);
        chk("R10 idx loaded", int'(idx_out[0]), 77);
        do_access(0, MODE_POST_IMM, 0, 8'd0, "R10 readback");

        // R2: modifier load in the same cycle as a request uses the old modifier
        set_wr(0, RK_MODIFY, 0, 5); step();
        set_req(0, MODE_POST_REG, 0, 8'h00);
        set_wr(0, RK_MODIFY, 0, 9);
        step();
        chk("R2 old modifier addr", int'(addr_out[0]), 77);
        chk("R2 old modifier idx", int'(idx_out[0]), 82);
        mI[0][0] = 82;
        do_access(0, MODE_POST_REG, 0, 8'h00, "R2 new modifier");
        chk("R2 new modifier value", mI[0][0], 91);

        // R12: sets are independent
        set_wr(0, RK_INDEX, 2, 600); step();
        do_access(0, MODE_POST_IMM, 0, 8'd1, "R12 other set");
        do_access(0, MODE_POST_IMM, 2, 8'd0, "R12 untouched set");
        chk("R12 set2 value", mI[0][2], 600);

        // R11: both generators in the same cycle
        set_wr(0, RK_INDEX, 0, 1000);
        set_wr(1, RK_INDEX, 0, 2000);
        step();
        set_req(0, MODE_POST_IMM, 0, 8'd4);
        set_req(1, MODE_PRE_IMM, 0, 8'hF0);
        step();
        chk("R11 g0 addr", int'(addr_out[0]), 1000);
        chk("R11 g0 idx", int'(idx_out[0]), 1004);
        chk("R11 g1 addr", int'(addr_out[1]), 1984);
        chk("R11 g1 idx", int'(idx_out[1]), 2000);
        chk("R11 both valid", int'(addr_valid), 3);

        // R9: idle cycle drops valid and holds outputs
        step();
        chk("R9 idle valid", int'(addr_valid), 0);
        chk("R9 idle addr hold", int'(addr_out[1]), 1984);
        chk("R9 idle idx hold", int'(idx_out[0]), 1004);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule